// File: doc/BRIEF.md
# Overcurrent Port Fault Latch with Edge-Triggered Re-Arm

This block guards a set of power ports, one channel per port. Each channel watches a digital overcurrent sense input. It resynchronises that input to the local clock and drives an enable for its port. When a channel sees an overcurrent indication, it latches its port off. The port stays off after the sense input returns low.

Software brings a channel back through a 16-bit control word on a small synchronous register bus. A channel is re-armed only when its control bit goes from 0 to 1. Holding the bit high does nothing more. If the overcurrent is still present when the re-arm edge is seen, the attempt is used up and the port stays off. A fresh 0-to-1 edge is then needed once the fault has cleared. Reading the control word returns the last value written to it. A second, read-only address reports which channels are currently latched off.

Top module: `ocp_latch_ctrl`

## Requirements
- R1: After reset every port enable is 1, the control word reads 0 and the status word reads 0.
- R2: A sense input passes through a two-stage synchronizer. A sense level applied before clock edge k turns the port enable off on edge k+2 and not earlier.
- R3: Once a channel is latched off, its port enable stays 0 after the sense input returns low, until a valid re-arm.
- R4: When control bit n goes from 0 to 1 on write edge k and synchronized sense n is low, channel n is re-armed on edge k+1 and its port enable returns to 1.
- R5: Writing 1 to a control bit that is already 1 starts no re-arm.
- R6: A re-arm edge that arrives while synchronized sense is high is consumed and the port stays off. The channel recovers only after the fault has cleared and a new 0-to-1 edge is written.
- R7: When a fault and a re-arm edge reach a channel in the same cycle, the fault wins and the channel stays latched.
- R8: A write to address 0 stores all 16 bits of write data. A read of address 0 returns exactly that value.
- R9: A read of address 1 returns the latched-off bits, with bit n set when channel n is off. Writes to address 1 are ignored.
- R10: Channels are independent. A fault or re-arm on one channel leaves every other channel's enable unchanged.
- R11: Read data is registered. It updates on the edge where the read strobe is high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 16 | Overcurrent sense, one bit per channel, asynchronous |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register select: 0 control word, 1 status word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| port_en_o | output | 16 | Port enables, 1 means the port is on |

## Verification
The latch is tried with the following sense patterns:
- A single-channel level held for several cycles, which pins down the synchronizer delay to the exact edge.
- A sense pulse that is released early, which separates latching from simply following the input.
- A multi-channel checkerboard, which exposes crosstalk between channels.

The re-arm path is tried with the following writes:
- A clean 0-to-1 write.
- A repeated 1.
- A rising edge while the fault persists.
- A rising edge in the same cycle that a new fault arrives.

Together these separate level-triggered from edge-triggered behaviour, and consumed re-arms from deferred ones. A behavioural model in the bench shadows every cycle, so a one-cycle timing slip is also caught.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    SEL_CTL  = 1'b0,
    SEL_STAT = 1'b1
  } sel_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ocp_rearm_reg.sv
module ocp_rearm_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] ctl_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= ctl_q;
      if (we_i) ctl_q <= wdata_i;
    end
  end

  assign ctl_o  = ctl_q;
  assign rise_o = ctl_q & ~prev_q;

  // R8
  store_word_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (ctl_q == $past(wdata_i)));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ocp_chan_latch.sv
module ocp_chan_latch (
  input  logic clk,
  input  logic rst,
  input  logic sense_i,
  input  logic rearm_i,
  output logic off_o
);
  logic off_q;

  always_ff @(posedge clk) begin
    if (rst)            off_q <= 1'b0;
    else if (sense_i)   off_q <= 1'b1;
    else if (rearm_i)   off_q <= 1'b0;
  end

  assign off_o = off_q;

  // R7
  fault_wins_chk: assert property (@(posedge clk) disable iff (rst)
    sense_i |=> off_q);

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (off_q && !rearm_i) |=> off_q);

  // R4
  rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (off_q && rearm_i && !sense_i) |=> !off_q);

  // R2
  no_spurious_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (!off_q && !sense_i) |=> !off_q);
endmodule

// File: rtl/ocp_latch_ctrl.sv
module ocp_latch_ctrl #(
  parameter int unsigned NCH         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sense_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic           addr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] rdata_o,
  output logic [NCH-1:0] port_en_o
);
  import ocp_pkg::*;

  logic [NCH-1:0] sense_s;
  logic [NCH-1:0] ctl_w;
  logic [NCH-1:0] rise_w;
  logic [NCH-1:0] off_w;
  logic [NCH-1:0] rdata_q;
  logic           ctl_we;

  ocp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sense_i),
    .q_o (sense_s)
  );

  assign ctl_we = wr_en_i && (addr_i == SEL_CTL);

  ocp_rearm_reg #(.W(NCH)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we_i    (ctl_we),
    .wdata_i (wdata_i),
    .ctl_o   (ctl_w),
    .rise_o  (rise_w)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    ocp_chan_latch u_lat (
      .clk     (clk),
      .rst     (rst),
      .sense_i (sense_s[n]),
      .rearm_i (rise_w[n]),
      .off_o   (off_w[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= (addr_i == SEL_STAT) ? off_w : ctl_w;
  end

  assign rdata_o   = rdata_q;
  assign port_en_o = ~off_w;

  // R9
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == SEL_STAT) |=> (rdata_o == ~$past(port_en_o)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_ocp_latch_ctrl.sv
`timescale 1ns/1ps
module sim_ocp_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sense = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, port_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ocp_latch_ctrl u0 (
    .clk(clk), .rst(rst), .sense_i(sense), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .port_en_o(port_en)
  );

  // Behavioural reference: queue for the synchronizer delay, integers for bits
  logic [15:0] dq[$];
  logic [15:0] m_ctl, m_prev, m_flt, m_rd;
  initial begin dq = '{16'h0, 16'h0}; m_ctl = 0; m_prev = 0; m_flt = 0; m_rd = 0; end

  always @(posedge clk) begin
    if (rst) begin
      dq = '{16'h0, 16'h0}; m_ctl = 0; m_prev = 0; m_flt = 0; m_rd = 0;
    end else begin
      logic [15:0] s, rise, nf;
      s = dq[0];
      rise = m_ctl & ~m_prev;
      nf = 0;
      for (int i = 0; i < 16; i++)
        nf[i] = s[i] ? 1'b1 : (rise[i] ? 1'b0 : m_flt[i]);
      if (rd_en) m_rd = addr ? m_flt : m_ctl;
      m_prev = m_ctl;
      if (wr_en && !addr) m_ctl = wdata;
      void'(dq.pop_front());
      dq.push_back(sense);
      m_flt = nf;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R2 R3 R10 model port_en", port_en, ~m_flt);
    chk("R11 model rdata", rdata, m_rd);
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic a, logic [15:0] d);
    wr_en = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic a, output logic [15:0] v);
    rd_en = 1; addr = a; @(negedge clk); rd_en = 0; v = rdata;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3); rst = 0; @(negedge clk);
    // R1 reset state
    chk("R1 port_en", port_en, 16'hFFFF);
    rd(0, v); chk("R1 ctl", v, 16'h0000);
    rd(1, v); chk("R1 status", v, 16'h0000);

    // R2 synchronizer delay, R3 latch hold
    sense[3] = 1; cyc(2);
    chk("R2 before edge k+2", port_en, 16'hFFFF);
    cyc(1);
    chk("R2 at edge k+2", port_en, 16'hFFF7);
    sense[3] = 0; cyc(5);
    chk("R3 held off", port_en, 16'hFFF7);
    rd(1, v); chk("R9 status", v, 16'h0008);

    // R4 clean re-arm
    wr(0, 16'h0008); cyc(1);
    chk("R4 rearm", port_en, 16'hFFFF);
    rd(0, v); chk("R8 readback", v, 16'h0008);

    // R5 holding 1 starts no re-arm
    sense[3] = 1; cyc(3); sense[3] = 0; cyc(3);
    wr(0, 16'h0008); cyc(2);
    chk("R5 held bit no rearm", port_en, 16'hFFF7);

    // R6 re-arm while fault persists is consumed
    sense[5] = 1; cyc(4);
    wr(0, 16'h0020); cyc(2);
    chk("R6 consumed", port_en, 16'hFFD7);
    sense[5] = 0; cyc(4);
    chk("R6 still off after clear", port_en, 16'hFFD7);
    wr(0, 16'h0000); wr(0, 16'h0028); cyc(1);
    chk("R6 new edge recovers", port_en, 16'hFFFF);

    // R7 fault and re-arm edge in the same cycle
    sense[7] = 1; cyc(4); sense[7] = 0; cyc(3);
    chk("R7 latched", port_en, 16'hFF7F);
    sense[7] = 1; cyc(1);
    wr(0, 16'h00A8); cyc(1);
    chk("R7 fault wins", port_en, 16'hFF7F);
    sense[7] = 0; cyc(4);
    chk("R7 stays latched", port_en, 16'hFF7F);
    wr(0, 16'h0028); wr(0, 16'h00A8); cyc(1);
    chk("R7 recovers on new edge", port_en, 16'hFFFF);

    // R9 writes to status address ignored
    wr(1, 16'hFFFF); cyc(2);
    rd(0, v); chk("R9 ctl untouched", v, 16'h00A8);
    rd(1, v); chk("R9 status untouched", v, 16'h0000);
    chk("R9 ports untouched", port_en, 16'hFFFF);

    // R8 full-width readback
    wr(0, 16'h5A3C); rd(0, v); chk("R8 pattern", v, 16'h5A3C);
    // R11 hold without read strobe
    cyc(3); chk("R11 rdata hold", rdata, 16'h5A3C);

    // R10 multi-channel independence
    wr(0, 16'h0000);
    sense = 16'hA5A5; cyc(1); sense = 16'h0000; cyc(4);
    chk("R10 checkerboard", port_en, 16'h5A5A);
    rd(1, v); chk("R10 status", v, 16'hA5A5);
    wr(0, 16'h0005); cyc(1);
    chk("R10 partial rearm", port_en, 16'h5A5F);
    wr(0, 16'hFFFF); cyc(1);
    chk("R10 full rearm", port_en, 16'hFFFF);

    cyc(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule